// File: doc/BRIEF.md
# SMBus Register Target

This block is a slave-only target on a two-wire SMBus. It watches the clock line and the data line. Both arrive already synchronised to the system clock. It answers a single fixed 7-bit device address. Its only bus output is an enable that pulls the open-drain data line low. It handles four transaction shapes: write-byte, read-byte, send-byte and receive-byte. Each transaction reaches a small register set.

The register set holds two writable control fields. One is a 5-bit brightness level and the other is a 3-bit shutdown mode; both drive downstream control logic directly. A 2-bit status value comes in from outside and can be read but not written. Three constant identification bytes are also readable. Every transaction that carries a command byte stores that command in a pointer. A send-byte only updates the pointer. A receive-byte returns whatever register the pointer currently selects.

Top module: `smbus_reg_target`

## Requirements
- R1: After reset, brightness and shutdown mode are 0, the data line is not pulled, and the command pointer selects brightness (command 0x01), so a receive-byte returns the brightness value.
- R2: The address byte is matched against 7'b0101100 in its upper seven bits, MSB first, with bit 0 as direction (0 write, 1 read). A match is acknowledged by pulling SDA low in the ninth clock. A mismatch is not acknowledged, and every later byte is ignored and left unacknowledged until the next START.
- R3: In a write-byte, the data byte is stored into the register named by the command byte: 0x01 brightness (low 5 bits kept) or 0x02 shutdown mode (low 3 bits kept). Command and data bytes are both acknowledged.
- R4: In a read-byte (write address, command, repeated START, read address), the target sends the selected register MSB first. The unused upper bits of a narrow register come out as zero.
- R5: A send-byte (address, command, STOP) sets the pointer and changes no register.
- R6: A receive-byte (read address only) returns the register named by the most recent command byte, whether that byte came from a write-byte, read-byte or send-byte.
- R7: Command 0x03 reads the external status input. Commands 0xFD, 0xFE and 0xFF read the chip revision, manufacturer ID and chip ID bytes. Writes to any of these are acknowledged and have no effect.
- R8: Any other command code is acknowledged, reads back 0x00, and ignores writes.
- R9: The pull-low enable changes only while SCL is low. It is released after each acknowledge bit and after the eighth bit of a transmitted byte, and it is never active while the target is idle or ignoring the bus.
- R10: A START inside any byte abandons the transfer in progress without side effects and restarts address reception.
- R11: Once a write-byte's data byte has been accepted, further bytes before STOP are not acknowledged and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SMBus clock sample |
| sda_i | input | 1 | Synchronised SMBus data sample |
| status_i | input | STAT_W (2) | Status value presented on command 0x03 |
| sda_pull_o | output | 1 | Drive SDA low when 1 |
| bright_o | output | BRIGHT_W (5) | Brightness register |
| shdn_o | output | SHDN_W (3) | Shutdown-mode register |

## Verification
Address reception can be aborted in the same cycle that a byte is being shifted in, because a START can land on any bit. The bench provokes this by sending three bits of a data byte and then issuing a START. It then runs a complete write to a different register, and judges the result by reading back both control outputs: the interrupted byte must have left no trace. The second case is a write that ends in the same transaction as an attempt to overrun it. A stray ninth-bit byte after the data must be left unacknowledged, and the register must keep the value just written.

// File: rtl/smbus_reg_target.sv
module smbus_reg_target #(
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  parameter logic [7:0] CHIP_ID  = 8'h4C,
  parameter logic [7:0] REV_ID   = 8'h02,
  parameter logic [7:0] MFR_ID   = 8'h4D,
  parameter int BRIGHT_W = 5,
  parameter int SHDN_W   = 3,
  parameter int STAT_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [STAT_W-1:0] status_i,
  output logic              sda_pull_o,
  output logic [BRIGHT_W-1:0] bright_o,
  output logic [SHDN_W-1:0]   shdn_o
);
  localparam logic [7:0] CMD_BRIGHT = 8'h01;
  localparam logic [7:0] CMD_SHDN   = 8'h02;
  localparam logic [7:0] CMD_STAT   = 8'h03;
  localparam logic [7:0] CMD_REV    = 8'hFD;
  localparam logic [7:0] CMD_MFR    = 8'hFE;
  localparam logic [7:0] CMD_CHIP   = 8'hFF;

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_CMD, ST_WDATA, ST_RDATA, ST_WAITP} st_t;

  st_t        st;
  logic       scl_q, sda_q, ack_drv;
  logic [3:0] bitn;
  logic [7:0] sh, txsh, ptr, rd_byte;

  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire start    = scl_i & scl_q & sda_q & ~sda_i;
  wire stop     = scl_i & scl_q & ~sda_q & sda_i;

  assign sda_pull_o = ack_drv | ((st == ST_RDATA) & ~txsh[7]);

  always_comb begin
    case (ptr)
      CMD_BRIGHT: rd_byte = 8'(bright_o);
      CMD_SHDN:   rd_byte = 8'(shdn_o);
      CMD_STAT:   rd_byte = 8'(status_i);
      CMD_REV:    rd_byte = REV_ID;
      CMD_MFR:    rd_byte = MFR_ID;
      CMD_CHIP:   rd_byte = CHIP_ID;
      default:    rd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      ack_drv  <= 1'b0;
      bitn     <= '0;
      sh       <= '0;
      txsh     <= 8'hFF;
      ptr      <= CMD_BRIGHT;
      bright_o <= '0;
      shdn_o   <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start) begin
        st      <= ST_ADDR;
        bitn    <= '0;
        ack_drv <= 1'b0;
      end else if (stop) begin
        st      <= ST_IDLE;
        bitn    <= '0;
        ack_drv <= 1'b0;
      end else if (st == ST_RDATA) begin
        if (scl_fall) begin
          if (bitn == 4'd7) st <= ST_WAITP;
          else begin
            txsh <= {txsh[6:0], 1'b1};
            bitn <= bitn + 4'd1;
          end
        end
      end else if (st == ST_ADDR || st == ST_CMD || st == ST_WDATA) begin
        if (scl_rise && bitn < 4'd8) begin
          sh   <= {sh[6:0], sda_i};
          bitn <= bitn + 4'd1;
        end else if (scl_fall && bitn == 4'd8) begin
          bitn <= 4'd9;
          case (st)
            ST_ADDR: begin
              if (sh[7:1] == DEV_ADDR) ack_drv <= 1'b1;
              else st <= ST_WAITP;
            end
            ST_CMD: begin
              ptr     <= sh;
              ack_drv <= 1'b1;
            end
            default: begin
              ack_drv <= 1'b1;
              if (ptr == CMD_BRIGHT) bright_o <= sh[BRIGHT_W-1:0];
              if (ptr == CMD_SHDN)   shdn_o   <= sh[SHDN_W-1:0];
            end
          endcase
        end else if (scl_fall && bitn == 4'd9) begin
          ack_drv <= 1'b0;
          bitn    <= '0;
          case (st)
            ST_ADDR: begin
              if (sh[0]) begin
                st   <= ST_RDATA;
                txsh <= rd_byte;
              end else st <= ST_CMD;
            end
            ST_CMD:  st <= ST_WDATA;
            default: st <= ST_WAITP;
          endcase
        end
      end
    end
  end

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> !scl_i); // R9
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE || st == ST_WAITP) |-> !sda_pull_o); // R2
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !sda_pull_o); // R10
  AST_BRIGHT_ONLY_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (bright_o != $past(bright_o)) |-> ($past(st) == ST_WDATA)); // R3
  AST_SHDN_ONLY_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_o != $past(shdn_o)) |-> ($past(st) == ST_WDATA)); // R3
endmodule

// File: tb/smbus_reg_target_bench.sv
module smbus_reg_target_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic [1:0] status = 2'b10;
  logic sda_pull;
  logic [4:0] bright;
  logic [2:0] shdn;
  logic sda_line;
  int checks = 0;
  int errors = 0;

  assign sda_line = m_sda & ~sda_pull;

  always #5 clk = ~clk;

  smbus_reg_target #(.CHIP_ID(8'hC3), .REV_ID(8'h17), .MFR_ID(8'h9A)) u_smbus_reg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .status_i(status),
    .sda_pull_o(sda_pull), .bright_o(bright), .shdn_o(shdn));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hold(4); scl = 1'b1; hold(4); m_sda = 1'b0; hold(4); scl = 1'b0; hold(4);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hold(4); scl = 1'b1; hold(4); m_sda = 1'b1; hold(6);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; hold(4); scl = 1'b1; hold(8); scl = 1'b0; hold(4);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; hold(4); scl = 1'b1; hold(4); b = sda_line; hold(4); scl = 1'b0; hold(4);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(ack);
  endtask

  task automatic get_byte(output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(1'b1);
  endtask

  task automatic do_write(input logic [7:0] cmd, input logic [7:0] data, input string req);
    logic a;
    bus_start();
    put_byte(8'h58, a); check({req, " addr ack"}, 8'(a), 8'h00);
    put_byte(cmd, a);   check({req, " cmd ack"}, 8'(a), 8'h00);
    put_byte(data, a);  check({req, " data ack"}, 8'(a), 8'h00);
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] cmd, output logic [7:0] d);
    logic a;
    bus_start();
    put_byte(8'h58, a);
    put_byte(cmd, a);
    bus_start();
    put_byte(8'h59, a);
    get_byte(d);
    bus_stop();
  endtask

  task automatic do_send(input logic [7:0] cmd);
    logic a;
    bus_start();
    put_byte(8'h58, a);
    put_byte(cmd, a);
    bus_stop();
  endtask

  task automatic do_recv(output logic [7:0] d);
    logic a;
    bus_start();
    put_byte(8'h59, a);
    get_byte(d);
    bus_stop();
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; hold(3); rst_n = 1'b1; hold(3);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_write(8'h01, 8'h0B, "R1");
    do_send(8'hFF);
    apply_reset();
    check("R1 bright", 8'(bright), 8'h00);
    check("R1 shdn", 8'(shdn), 8'h00);
    check("R1 pull", 8'(sda_pull), 8'h00);
    do_recv(d);
    check("R1 pointer on brightness", d, 8'h00);
  endtask

  task automatic t_write_read();
    logic [7:0] d;
    do_write(8'h01, 8'hFF, "R3");
    check("R3 bright masked", 8'(bright), 8'h1F);
    do_write(8'h02, 8'hF5, "R3");
    check("R3 shdn masked", 8'(shdn), 8'h05);
    do_read(8'h01, d);
    check("R4 read bright", d, 8'h1F);
    do_read(8'h02, d);
    check("R4 read shdn upper zero", d, 8'h05);
    do_write(8'h01, 8'h0A, "R3");
    do_read(8'h01, d);
    check("R4 read bright pattern", d, 8'h0A);
    check("R9 released after read", 8'(sda_pull), 8'h00);
  endtask

  task automatic t_pointer();
    logic [7:0] d;
    do_send(8'h02);
    check("R5 send keeps bright", 8'(bright), 8'h0A);
    check("R5 send keeps shdn", 8'(shdn), 8'h05);
    do_recv(d);
    check("R5 recv after send", d, 8'h05);
    do_read(8'hFE, d);
    do_recv(d);
    check("R6 recv after read-byte", d, 8'h9A);
    do_write(8'h01, 8'h13, "R6");
    do_recv(d);
    check("R6 recv after write-byte", d, 8'h13);
  endtask

  task automatic t_read_only();
    logic [7:0] d;
    do_read(8'h03, d);   check("R7 status", d, 8'h02);
    do_read(8'hFD, d);   check("R7 revision", d, 8'h17);
    do_read(8'hFF, d);   check("R7 chip id", d, 8'hC3);
    do_write(8'h03, 8'hFF, "R7");
    do_read(8'h03, d);   check("R7 status unchanged", d, 8'h02);
    do_write(8'hFF, 8'h00, "R7");
    do_read(8'hFF, d);   check("R7 chip id unchanged", d, 8'hC3);
    check("R7 bright untouched", 8'(bright), 8'h13);
  endtask

  task automatic t_unknown();
    logic [7:0] d;
    do_write(8'h40, 8'h1C, "R8");
    do_read(8'h40, d);
    check("R8 unknown reads zero", d, 8'h00);
    check("R8 bright untouched", 8'(bright), 8'h13);
    check("R8 shdn untouched", 8'(shdn), 8'h05);
  endtask

  task automatic t_bad_addr();
    logic a;
    bus_start();
    put_byte(8'h5A, a); check("R2 foreign addr nack", 8'(a), 8'h01);
    put_byte(8'h01, a); check("R2 ignored cmd nack", 8'(a), 8'h01);
    put_byte(8'h07, a); check("R2 ignored data nack", 8'(a), 8'h01);
    bus_stop();
    check("R2 bright unchanged", 8'(bright), 8'h13);
  endtask

  task automatic t_start_abort();
    logic a;
    bus_start();
    put_byte(8'h58, a);
    put_byte(8'h01, a);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    bus_start();
    put_byte(8'h58, a); check("R10 addr after abort ack", 8'(a), 8'h00);
    put_byte(8'h02, a);
    put_byte(8'h03, a);
    bus_stop();
    check("R10 aborted byte no effect", 8'(bright), 8'h13);
    check("R10 new write lands", 8'(shdn), 8'h03);
  endtask

  task automatic t_extra_byte();
    logic a;
    bus_start();
    put_byte(8'h58, a);
    put_byte(8'h01, a);
    put_byte(8'h11, a); check("R11 data ack", 8'(a), 8'h00);
    put_byte(8'h07, a); check("R11 extra byte nack", 8'(a), 8'h01);
    bus_stop();
    check("R11 value kept", 8'(bright), 8'h11);
    check("R9 idle no pull", 8'(sda_pull), 8'h00);
  endtask

  initial begin
    hold(3);
    rst_n = 1'b1;
    hold(3);
    t_reset();
    t_write_read();
    t_pointer();
    t_read_only();
    t_unknown();
    t_bad_addr();
    t_start_abort();
    t_extra_byte();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule